// File: doc/BRIEF.md
# Two-Port LAN Enable Gate and Host Function Mapper

This block decides which of the two network ports of a controller are alive and how the two host bus function slots are assigned to them. Each port has an active-low disable pin. The block samples that pin only when the host reset is released or when an in-band reset completes. A third active-low pin turns the whole device off at once, with no clock involved.

The block combines the sampled pin state with static configuration bits from non-volatile memory and with a function-select strap. From these it drives a power-down request for each port's PHY and MAC, a device-wide deep power-down request, and an encoded owner for each host function slot. When one port is gone, a slot may be filled by a dummy placeholder. When both ports are gone, every host function is withdrawn. The configuration bits are treated as already valid and steady.

Top module: `lpg_top`

## Requirements
- R1: While `rst` is high and on the first cycles after it, `slot0_map` = 0, `slot1_map` = 1, `port_pd` = 0 and `fn_all_off` = 0. Slot codes are 0 = port 0, 1 = port 1, 2 = dummy, 3 = absent.
- R2: A cycle in which `host_rst_n` is high and was low on the previous clock, or is the first cycle after `rst`, captures `~port_off_n` into the latched pin state (bit i = port i disabled).
- R3: A one-cycle high on `ib_rst_end` also captures `~port_off_n` into the latched pin state.
- R4: Changes on `port_off_n` at any other time have no effect on `port_pd`, `slot0_map`, `slot1_map` or `fn_all_off`.
- R5: A port whose latched pin is disabled raises its `port_pd` bit only when `cfg_pin_pd_en` is 1. With it at 0 the port stays powered.
- R6: `cfg_lan_off[i]` = 1 disables port i and raises `port_pd[i]` whatever `cfg_pin_pd_en` is.
- R7: `cfg_fn_off[i]` = 1 removes port i from the slot mapping but leaves `port_pd[i]` low.
- R8: With both ports present, `fn_sel` = 0 gives slots (0,1) and `fn_sel` = 1 gives slots (1,0).
- R9: With only port 0 gone, `fn_sel` = 0 gives (2,1) and `fn_sel` = 1 gives (1,3). With only port 1 gone, `fn_sel` = 0 gives (0,3) and `fn_sel` = 1 gives (2,0).
- R10: With both ports gone, both slots read 3 and `fn_all_off` = 1, for either `fn_sel`.
- R11: `dev_pd` is high in the same cycle that `dev_off_n` is low, with no clock edge. Once the synchronized copy is high, both slots read 3 and `fn_all_off` = 1.
- R12: After `dev_off_n` returns high, `dev_pd` stays high until `SYNC_STAGES` clock edges have seen it high, and then drops.
- R13: `port_pd`, the slot codes and `fn_all_off` are registered and follow the latched state and configuration one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rst_n | input | 1 | Host reset, active low; its release triggers pin capture |
| ib_rst_end | input | 1 | One-cycle pulse marking the end of an in-band reset |
| port_off_n | input | 2 | Per-port disable pins, active low |
| dev_off_n | input | 1 | Whole-device disable, active low, asynchronous |
| cfg_pin_pd_en | input | 1 | Policy: pin-disabled ports also power down |
| cfg_lan_off | input | 2 | Per-port LAN disable from configuration memory |
| cfg_fn_off | input | 2 | Per-port host-function-only disable |
| fn_sel | input | 1 | Function-select strap |
| port_pd | output | 2 | Per-port PHY/MAC power-down request |
| dev_pd | output | 1 | Device deep power-down request |
| slot0_map | output | 2 | Owner code of host function slot 0 |
| slot1_map | output | 2 | Owner code of host function slot 1 |
| fn_all_off | output | 1 | All host functions withdrawn |

## Verification
The bench moves the disable pins while no capture event is pending. A design that sampled them level-sensitively would then show ports vanishing from the map. It holds the host reset low and releases it, and it pulses the in-band end separately, so a design that missed either trigger keeps stale slot codes. Every single-port-gone case is run under both strap values, because a swapped dummy and absent code is the likeliest table error. The policy bit and the two configuration disables are toggled in turn, so that confusing the function-only bit with the LAN bit shows up as a spurious `port_pd`. The device pin is pulsed to expose a power-down that waits for the clock or drops before the synchronizer has cleared.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int NPORTS = 2;

  typedef enum logic [1:0] {
    MAP_P0    = 2'd0,
    MAP_P1    = 2'd1,
    MAP_DUMMY = 2'd2,
    MAP_NONE  = 2'd3
  } slot_map_e;
endpackage

// File: rtl/lpg_pin_latch.sv
module lpg_pin_latch #(
  parameter int NPORTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rst_n,
  input  logic              ib_rst_end,
  input  logic [NPORTS-1:0] port_off_n,
  output logic [NPORTS-1:0] lat_dis
);
  logic host_q;
  logic capture;

  // rst leaves host_q low, so a released host reset is captured right after
  assign capture = (host_rst_n & ~host_q) | ib_rst_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_q  <= 1'b0;
      lat_dis <= '0;
    end else begin
      host_q <= host_rst_n;
      if (capture) lat_dis <= ~port_off_n;
    end
  end
endmodule

// File: rtl/lpg_dev_sync.sv
module lpg_dev_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dev_off_n,
  output logic dev_sync,
  output logic dev_pd
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], ~dev_off_n};
  end

  assign dev_sync = chain[STAGES-1];
  // raise without a clock, drop only once the synchronized copy clears
  assign dev_pd   = ~dev_off_n | dev_sync;
endmodule

// File: rtl/lpg_fn_map.sv
module lpg_fn_map
  import lpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] port_gone,
  input  logic       fn_sel,
  input  logic       dev_sync,
  output logic [1:0] slot0_map,
  output logic [1:0] slot1_map,
  output logic       fn_all_off
);
  slot_map_e s0_n, s1_n;
  logic      off_n;

  always_comb begin
    off_n = 1'b0;
    s0_n  = MAP_NONE;
    s1_n  = MAP_NONE;
    if (dev_sync || (&port_gone)) begin
      off_n = 1'b1;
    end else if (port_gone == 2'b00) begin
      s0_n = fn_sel ? MAP_P1 : MAP_P0;
      s1_n = fn_sel ? MAP_P0 : MAP_P1;
    end else begin
      // one port left: the slot meant for the lost port is dummy or absent
      if (port_gone[0]) begin
        s0_n = fn_sel ? MAP_P1 : MAP_DUMMY;
        s1_n = fn_sel ? MAP_NONE : MAP_P1;
      end else begin
        s0_n = fn_sel ? MAP_DUMMY : MAP_P0;
        s1_n = fn_sel ? MAP_P0 : MAP_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot0_map  <= MAP_P0;
      slot1_map  <= MAP_P1;
      fn_all_off <= 1'b0;
    end else begin
      slot0_map  <= s0_n;
      slot1_map  <= s1_n;
      fn_all_off <= off_n;
    end
  end
endmodule

// File: rtl/lpg_top.sv
module lpg_top
  import lpg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_rst_n,
  input  logic       ib_rst_end,
  input  logic [1:0] port_off_n,
  input  logic       dev_off_n,
  input  logic       cfg_pin_pd_en,
  input  logic [1:0] cfg_lan_off,
  input  logic [1:0] cfg_fn_off,
  input  logic       fn_sel,
  output logic [1:0] port_pd,
  output logic       dev_pd,
  output logic [1:0] slot0_map,
  output logic [1:0] slot1_map,
  output logic       fn_all_off
);
  logic [NPORTS-1:0] lat_dis;
  logic [NPORTS-1:0] port_gone;
  logic              dev_sync;

  lpg_pin_latch #(.NPORTS(NPORTS)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .host_rst_n (host_rst_n),
    .ib_rst_end (ib_rst_end),
    .port_off_n (port_off_n),
    .lat_dis    (lat_dis)
  );

  lpg_dev_sync #(.STAGES(SYNC_STAGES)) u_dev (
    .clk       (clk),
    .rst       (rst),
    .dev_off_n (dev_off_n),
    .dev_sync  (dev_sync),
    .dev_pd    (dev_pd)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NPORTS; gi++) begin : g_port
      assign port_gone[gi] = lat_dis[gi] | cfg_lan_off[gi] | cfg_fn_off[gi];
      always_ff @(posedge clk) begin
        if (rst) port_pd[gi] <= 1'b0;
        else     port_pd[gi] <= (lat_dis[gi] & cfg_pin_pd_en) | cfg_lan_off[gi];
      end
    end
  endgenerate

  lpg_fn_map u_map (
    .clk        (clk),
    .rst        (rst),
    .port_gone  (port_gone),
    .fn_sel     (fn_sel),
    .dev_sync   (dev_sync),
    .slot0_map  (slot0_map),
    .slot1_map  (slot1_map),
    .fn_all_off (fn_all_off)
  );
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       dev_off_n,
  input logic [1:0] cfg_lan_off,
  input logic [1:0] cfg_fn_off,
  input logic [1:0] port_pd,
  input logic       dev_pd,
  input logic [1:0] slot0_map,
  input logic [1:0] slot1_map,
  input logic       fn_all_off
);
  localparam int CW = $clog2(SYNC_STAGES + 1) + 1;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !dev_off_n) hi_cnt <= '0;
    else if (hi_cnt < CW'(SYNC_STAGES)) hi_cnt <= hi_cnt + 1'b1;
  end

  always_comb begin
    if (!dev_off_n) assert_dev_immediate_R11: assert (dev_pd);
  end

  assert_dev_release_R12: assert property (@(posedge clk) disable iff (rst)
    (dev_off_n && hi_cnt >= CW'(SYNC_STAGES)) |-> !dev_pd);

  assert_lan_off_pd0_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_lan_off[0] |=> port_pd[0]);

  assert_lan_off_pd1_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_lan_off[1] |=> port_pd[1]);

  assert_fn_only_no_pd_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_fn_off[0] && !cfg_lan_off[0] && !cfg_fn_off[1] && !cfg_lan_off[1])
    |=> (slot0_map != 2'd0 && slot1_map != 2'd0));

  assert_all_off_R10: assert property (@(posedge clk) disable iff (rst)
    fn_all_off |-> (slot0_map == 2'd3 && slot1_map == 2'd3));

  assert_distinct_ports_R8: assert property (@(posedge clk) disable iff (rst)
    (slot0_map < 2'd2 && slot1_map < 2'd2) |-> (slot0_map != slot1_map));
endmodule

bind lpg_top lpg_checker #(.SYNC_STAGES(SYNC_STAGES)) u_lpg_checker (
  .clk         (clk),
  .rst         (rst),
  .dev_off_n   (dev_off_n),
  .cfg_lan_off (cfg_lan_off),
  .cfg_fn_off  (cfg_fn_off),
  .port_pd     (port_pd),
  .dev_pd      (dev_pd),
  .slot0_map   (slot0_map),
  .slot1_map   (slot1_map),
  .fn_all_off  (fn_all_off)
);

// File: tb/lpg_top_bench.sv
`timescale 1ns/1ps
module lpg_top_bench;
  localparam int SYNC_STAGES = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_rst_n = 1'b1;
  logic       ib_rst_end = 1'b0;
  logic [1:0] port_off_n = 2'b11;
  logic       dev_off_n = 1'b1;
  logic       cfg_pin_pd_en = 1'b0;
  logic [1:0] cfg_lan_off = 2'b00;
  logic [1:0] cfg_fn_off = 2'b00;
  logic       fn_sel = 1'b0;
  logic [1:0] port_pd;
  logic       dev_pd;
  logic [1:0] slot0_map, slot1_map;
  logic       fn_all_off;

  int compared = 0;
  int mismatched = 0;
  string phase = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  lpg_top #(.SYNC_STAGES(SYNC_STAGES)) u_lpg_top (
    .clk(clk), .rst(rst), .host_rst_n(host_rst_n), .ib_rst_end(ib_rst_end),
    .port_off_n(port_off_n), .dev_off_n(dev_off_n), .cfg_pin_pd_en(cfg_pin_pd_en),
    .cfg_lan_off(cfg_lan_off), .cfg_fn_off(cfg_fn_off), .fn_sel(fn_sel),
    .port_pd(port_pd), .dev_pd(dev_pd), .slot0_map(slot0_map),
    .slot1_map(slot1_map), .fn_all_off(fn_all_off)
  );

  // behavioural reference: what each output should be, from the requirements
  bit   m_host_q;
  bit   m_lat [2];
  bit   m_pd [2];
  int   m_s0 = 0, m_s1 = 1;
  bit   m_all;
  int   m_devq[$];

  function automatic void table_lookup(input bit g0, input bit g1, input bit sel,
                                       input bit dev, output int a, output int b,
                                       output bit off);
    off = 0;
    if (dev || (g0 && g1)) begin a = 3; b = 3; off = 1; end       // R10, R11
    else if (!g0 && !g1)   begin a = sel ? 1 : 0; b = sel ? 0 : 1; end  // R8
    else if (g0)           begin a = sel ? 1 : 2; b = sel ? 3 : 1; end  // R9
    else                   begin a = sel ? 2 : 0; b = sel ? 0 : 3; end  // R9
  endfunction

  function automatic bit dev_synced();
    int hits = 0;
    foreach (m_devq[k]) if (m_devq[k] != 0) hits++;
    return (m_devq.size() >= SYNC_STAGES) && (m_devq[0] != 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_host_q = 0;
      m_lat[0] = 0; m_lat[1] = 0;
      m_pd[0] = 0;  m_pd[1] = 0;
      m_s0 = 0; m_s1 = 1; m_all = 0;
      m_devq.delete();
    end else begin
      bit g0, g1, syn, off;
      int a, b;
      syn = dev_synced();
      g0 = m_lat[0] | cfg_lan_off[0] | cfg_fn_off[0];   // R7 takes slot away
      g1 = m_lat[1] | cfg_lan_off[1] | cfg_fn_off[1];
      table_lookup(g0, g1, fn_sel, syn, a, b, off);
      m_s0 = a; m_s1 = b; m_all = off;
      m_pd[0] = (m_lat[0] & cfg_pin_pd_en) | cfg_lan_off[0];  // R5, R6
      m_pd[1] = (m_lat[1] & cfg_pin_pd_en) | cfg_lan_off[1];
      if ((host_rst_n && !m_host_q) || ib_rst_end) begin      // R2, R3
        m_lat[0] = !port_off_n[0];
        m_lat[1] = !port_off_n[1];
      end
      m_host_q = host_rst_n;
      m_devq.push_back(!dev_off_n);
      while (m_devq.size() > SYNC_STAGES) void'(m_devq.pop_front());
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit exp_dev;
      exp_dev = !dev_off_n || (!rst && dev_synced());
      cmp("dev_pd", dev_pd, exp_dev);                      // R11, R12
      cmp("port_pd0", port_pd[0], m_pd[0]);
      cmp("port_pd1", port_pd[1], m_pd[1]);
      cmp("slot0_map", slot0_map, m_s0);
      cmp("slot1_map", slot1_map, m_s1);
      cmp("fn_all_off", fn_all_off, m_all);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ib();
    @(negedge clk); ib_rst_end = 1'b1;
    @(negedge clk); ib_rst_end = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #100000;
    phase = "watchdog";
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    phase = "R1";
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(3);
    phase = "R8";  fn_sel = 1'b0; wait_cyc(3);
    fn_sel = 1'b1; wait_cyc(3);
    phase = "R4";  port_off_n = 2'b10; wait_cyc(4);
    port_off_n = 2'b01; wait_cyc(3);
    port_off_n = 2'b10;
    phase = "R2";  host_rst_n = 1'b0; wait_cyc(2);
    host_rst_n = 1'b1; wait_cyc(3);
    phase = "R9";  fn_sel = 1'b0; wait_cyc(3);
    phase = "R5";  cfg_pin_pd_en = 1'b1; wait_cyc(3);
    port_off_n = 2'b11; wait_cyc(3);  // R4: no capture, pd stays
    phase = "R3";  port_off_n = 2'b01; pulse_ib(); wait_cyc(3);
    phase = "R9";  fn_sel = 1'b1; wait_cyc(3);
    phase = "R10"; port_off_n = 2'b00; pulse_ib(); wait_cyc(3);
    fn_sel = 1'b0; wait_cyc(3);
    phase = "R6";  port_off_n = 2'b11; cfg_pin_pd_en = 1'b0; pulse_ib();
    cfg_lan_off = 2'b01; wait_cyc(3);
    cfg_pin_pd_en = 1'b1; cfg_lan_off = 2'b10; wait_cyc(3);
    phase = "R7";  cfg_lan_off = 2'b00; cfg_fn_off = 2'b10; wait_cyc(3);
    fn_sel = 1'b1; cfg_fn_off = 2'b01; wait_cyc(3);
    cfg_fn_off = 2'b00; wait_cyc(2);
    phase = "R11"; dev_off_n = 1'b0; #1; cmp("dev_pd_immediate", dev_pd, 1);
    wait_cyc(4);
    phase = "R12"; dev_off_n = 1'b1; wait_cyc(5);
    phase = "R13"; fn_sel = 1'b0; wait_cyc(3);
    finish_run();
  end
endmodule